// File: doc/BRIEF.md
# Integer ALU with overflow detection

This block is the combinational integer execute unit of a 32-bit load/store core. Each cycle the issue stage presents an operation select, two register operands, an immediate that has already been sign-extended to the full width, and a constant shift amount. The unit returns the operation result together with three flags: a result-valid flag that tells the writeback stage to commit the value, an overflow flag that raises an arithmetic exception, and an illegal-operation flag.

Its operations are add and subtract, each in a trapping and a wrapping form, and add-immediate in both forms. It also covers the four bitwise operations and the zero-extended immediate forms of three of them, and load-upper-immediate. The set-less-than comparisons come in signed and unsigned forms, each against a register or the immediate. The shifts are left, logical right and arithmetic right, each by the constant amount or by the low bits of a register. When a trapping operation overflows, the unit raises the exception and withholds the write. It has no state and no clock.

Top module: `alu_exec`

## Requirements
- R1: For ADD (select 0) and ADDI (select 16, second operand `imm_i`), `ovf_o` is 1 exactly when both addends have the same sign bit and the sum's sign bit differs from theirs; when `ovf_o` is 1, `valid_o` is 0 and `result_o` is 0, otherwise `result_o` is the 32-bit sum.
- R2: For SUB (select 2), `ovf_o` is 1 exactly when `a_i` and `b_i` differ in sign and the difference `a_i - b_i` differs in sign from `a_i`; on overflow `valid_o` and `result_o` are 0, otherwise `result_o` is the difference.
- R3: ADDU (1), SUBU (3) and ADDIU (17) return the sum or difference modulo 2^32 and never set `ovf_o`.
- R4: AND (4), OR (5), XOR (6) and NOR (7) combine `a_i` and `b_i` bitwise; NOR returns the complement of the OR.
- R5: ANDI (8), ORI (9) and XORI (10) combine `a_i` with `imm_i[15:0]` zero-extended; `imm_i[31:16]` has no effect.
- R6: LUI (11) returns `imm_i[15:0]` in bits 31:16 and zeros in bits 15:0.
- R7: SLT (12) compares `a_i < b_i` signed, SLTU (13) compares them unsigned, SLTI (14) compares `a_i < imm_i` signed; the result is 1 when true and 0 otherwise.
- R8: SLTIU (15) compares `a_i` against the full sign-extended `imm_i`, both read as unsigned, returning 1 or 0.
- R9: SLL (18), SRL (19) and SRA (20) shift `b_i` by `shamt_i`; SRL fills with zeros and SRA with copies of `b_i[31]`.
- R10: SLLV (21), SRLV (22) and SRAV (23) shift `b_i` by `a_i[4:0]`, with the same fills; `a_i[31:5]` has no effect.
- R11: Selects 24 to 31 set `illegal_o` to 1, with `valid_o`, `ovf_o` and `result_o` all 0.
- R12: Every defined select (0 to 23) drives `illegal_o` to 0, and drives `valid_o` to 1 unless R1 or R2 reports overflow.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_i | input | 5 | Operation select, encoded as listed in the requirements |
| a_i | input | 32 | First register operand; the low 5 bits also give the variable shift amount |
| b_i | input | 32 | Second register operand; the value shifted by all shift forms |
| imm_i | input | 32 | Immediate, already sign-extended from 16 bits |
| shamt_i | input | 5 | Constant shift amount |
| result_o | output | 32 | Operation result, zero when not valid |
| valid_o | output | 1 | Result may be written back |
| ovf_o | output | 1 | Arithmetic overflow on a trapping operation |
| illegal_o | output | 1 | Undefined operation select |

## Verification
The unit is combinational, so a wrong decode or datapath shows at the ports in the same cycle as the input that causes it. The result or a flag for that select is then wrong for that vector alone. A decode entry that routes a select to the wrong unit, or that picks sign- rather than zero-extension, shows as soon as the operands have their sign bits set or the immediate has its upper half set. A fault in one barrel-shifter stage shows only for shift amounts that have the matching bit set. A flag fault such as a wrapping add that traps, or an overflow that still reports valid, shows only at the signed boundaries. The sweep therefore crosses every select with the extreme operand values and walks every shift amount.

// File: rtl/alu_pkg.sv
package alu_pkg;

  localparam int OP_W = 5;

  typedef enum logic [OP_W-1:0] {
    OP_ADD   = 5'd0,
    OP_ADDU  = 5'd1,
    OP_SUB   = 5'd2,
    OP_SUBU  = 5'd3,
    OP_AND   = 5'd4,
    OP_OR    = 5'd5,
    OP_XOR   = 5'd6,
    OP_NOR   = 5'd7,
    OP_ANDI  = 5'd8,
    OP_ORI   = 5'd9,
    OP_XORI  = 5'd10,
    OP_LUI   = 5'd11,
    OP_SLT   = 5'd12,
    OP_SLTU  = 5'd13,
    OP_SLTI  = 5'd14,
    OP_SLTIU = 5'd15,
    OP_ADDI  = 5'd16,
    OP_ADDIU = 5'd17,
    OP_SLL   = 5'd18,
    OP_SRL   = 5'd19,
    OP_SRA   = 5'd20,
    OP_SLLV  = 5'd21,
    OP_SRLV  = 5'd22,
    OP_SRAV  = 5'd23
  } alu_op_e;

  typedef enum logic [2:0] {
    UNIT_ARITH,
    UNIT_LOGIC,
    UNIT_LUI,
    UNIT_CMP,
    UNIT_SHIFT
  } unit_e;

  typedef enum logic [1:0] {
    LOG_AND,
    LOG_OR,
    LOG_XOR,
    LOG_NOR
  } log_fn_e;

  typedef enum logic [1:0] {
    SH_LL,
    SH_RL,
    SH_RA
  } sh_fn_e;

  typedef struct packed {
    logic    legal;
    unit_e   unit;
    logic    sub;
    logic    trap;
    logic    use_imm;
    logic    imm_zext;
    log_fn_e log_fn;
    logic    cmp_uns;
    sh_fn_e  sh_fn;
    logic    sh_var;
  } ctrl_t;

endpackage

// File: rtl/alu_decode.sv
module alu_decode
  import alu_pkg::*;
(
  input  logic [OP_W-1:0] op_i,
  output ctrl_t           ctrl_o
);

  always_comb begin
    ctrl_o        = '0;
    ctrl_o.legal  = 1'b1;
    ctrl_o.unit   = UNIT_ARITH;
    ctrl_o.log_fn = LOG_AND;
    ctrl_o.sh_fn  = SH_LL;
    case (op_i)
      OP_ADD:   ctrl_o.trap = 1'b1;
      OP_ADDU:  ;
      OP_SUB:   begin ctrl_o.sub = 1'b1; ctrl_o.trap = 1'b1; end
      OP_SUBU:  ctrl_o.sub = 1'b1;
      OP_ADDI:  begin ctrl_o.use_imm = 1'b1; ctrl_o.trap = 1'b1; end
      OP_ADDIU: ctrl_o.use_imm = 1'b1;
      OP_AND:   ctrl_o.unit = UNIT_LOGIC;
      OP_OR:    begin ctrl_o.unit = UNIT_LOGIC; ctrl_o.log_fn = LOG_OR; end
      OP_XOR:   begin ctrl_o.unit = UNIT_LOGIC; ctrl_o.log_fn = LOG_XOR; end
      OP_NOR:   begin ctrl_o.unit = UNIT_LOGIC; ctrl_o.log_fn = LOG_NOR; end
      OP_ANDI: begin
        ctrl_o.unit     = UNIT_LOGIC;
        ctrl_o.use_imm  = 1'b1;
        ctrl_o.imm_zext = 1'b1;
      end
      OP_ORI: begin
        ctrl_o.unit     = UNIT_LOGIC;
        ctrl_o.log_fn   = LOG_OR;
        ctrl_o.use_imm  = 1'b1;
        ctrl_o.imm_zext = 1'b1;
      end
      OP_XORI: begin
        ctrl_o.unit     = UNIT_LOGIC;
        ctrl_o.log_fn   = LOG_XOR;
        ctrl_o.use_imm  = 1'b1;
        ctrl_o.imm_zext = 1'b1;
      end
      OP_LUI:   ctrl_o.unit = UNIT_LUI;
      OP_SLT:   ctrl_o.unit = UNIT_CMP;
      OP_SLTU:  begin ctrl_o.unit = UNIT_CMP; ctrl_o.cmp_uns = 1'b1; end
      OP_SLTI:  begin ctrl_o.unit = UNIT_CMP; ctrl_o.use_imm = 1'b1; end
      // sign-extended immediate, unsigned compare
      OP_SLTIU: begin
        ctrl_o.unit    = UNIT_CMP;
        ctrl_o.use_imm = 1'b1;
        ctrl_o.cmp_uns = 1'b1;
      end
      OP_SLL:   ctrl_o.unit = UNIT_SHIFT;
      OP_SRL:   begin ctrl_o.unit = UNIT_SHIFT; ctrl_o.sh_fn = SH_RL; end
      OP_SRA:   begin ctrl_o.unit = UNIT_SHIFT; ctrl_o.sh_fn = SH_RA; end
      OP_SLLV:  begin ctrl_o.unit = UNIT_SHIFT; ctrl_o.sh_var = 1'b1; end
      OP_SRLV: begin
        ctrl_o.unit   = UNIT_SHIFT;
        ctrl_o.sh_fn  = SH_RL;
        ctrl_o.sh_var = 1'b1;
      end
      OP_SRAV: begin
        ctrl_o.unit   = UNIT_SHIFT;
        ctrl_o.sh_fn  = SH_RA;
        ctrl_o.sh_var = 1'b1;
      end
      default:  ctrl_o.legal = 1'b0;
    endcase
  end

endmodule

// File: rtl/alu_addsub.sv
module alu_addsub #(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0] a_i,
  input  logic [XLEN-1:0] b_i,
  input  logic            sub_i,
  output logic [XLEN-1:0] sum_o,
  output logic            ovf_o
);

  localparam int MSB = XLEN - 1;

  logic [XLEN-1:0] b_eff;

  assign b_eff = sub_i ? ~b_i : b_i;
  assign sum_o = a_i + b_eff + {{(XLEN-1){1'b0}}, sub_i};
  // operands agree in sign, result does not
  assign ovf_o = (a_i[MSB] == b_eff[MSB]) && (sum_o[MSB] != a_i[MSB]);

endmodule

// File: rtl/alu_logic.sv
module alu_logic
  import alu_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0] a_i,
  input  logic [XLEN-1:0] b_i,
  input  log_fn_e         fn_i,
  output logic [XLEN-1:0] res_o
);

  always_comb begin
    unique case (fn_i)
      LOG_AND: res_o = a_i & b_i;
      LOG_OR:  res_o = a_i | b_i;
      LOG_XOR: res_o = a_i ^ b_i;
      LOG_NOR: res_o = ~(a_i | b_i);
      default: res_o = '0;
    endcase
  end

endmodule

// File: rtl/alu_cmp.sv
module alu_cmp #(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0] a_i,
  input  logic [XLEN-1:0] b_i,
  input  logic            uns_i,
  output logic [XLEN-1:0] res_o
);

  logic lt;

  assign lt    = uns_i ? (a_i < b_i) : ($signed(a_i) < $signed(b_i));
  assign res_o = {{(XLEN-1){1'b0}}, lt};

endmodule

// File: rtl/alu_shift.sv
module alu_shift
  import alu_pkg::*;
#(
  parameter int XLEN    = 32,
  parameter int SHAMT_W = $clog2(XLEN)
) (
  input  logic [XLEN-1:0]    val_i,
  input  logic [SHAMT_W-1:0] amt_i,
  input  sh_fn_e             fn_i,
  output logic [XLEN-1:0]    res_o
);

  logic            left;
  logic            fill;
  logic [XLEN-1:0] src;
  logic [XLEN-1:0] acc;

  assign left = (fn_i == SH_LL);
  assign fill = (fn_i == SH_RA) && val_i[XLEN-1];

  // one right shifter; left shifts go through bit reversal
  always_comb begin
    for (int i = 0; i < XLEN; i++) begin
      src[i] = left ? val_i[XLEN-1-i] : val_i[i];
    end
  end

  always_comb begin
    acc = src;
    for (int k = 0; k < SHAMT_W; k++) begin
      if (amt_i[k]) begin
        acc = (acc >> (1 << k)) | (fill ? ~({XLEN{1'b1}} >> (1 << k)) : '0);
      end
    end
  end

  always_comb begin
    for (int i = 0; i < XLEN; i++) begin
      res_o[i] = left ? acc[XLEN-1-i] : acc[i];
    end
  end

endmodule

// File: rtl/alu_exec.sv
module alu_exec
  import alu_pkg::*;
#(
  parameter int XLEN    = 32,
  parameter int IMM_W   = 16,
  parameter int SHAMT_W = $clog2(XLEN)
) (
  input  logic [OP_W-1:0]    op_i,
  input  logic [XLEN-1:0]    a_i,
  input  logic [XLEN-1:0]    b_i,
  input  logic [XLEN-1:0]    imm_i,
  input  logic [SHAMT_W-1:0] shamt_i,
  output logic [XLEN-1:0]    result_o,
  output logic               valid_o,
  output logic               ovf_o,
  output logic               illegal_o
);

  localparam int PAD_W = XLEN - IMM_W;

  ctrl_t              ctrl;
  logic [XLEN-1:0]    imm_zx;
  logic [XLEN-1:0]    opnd_b;
  logic [XLEN-1:0]    arith_res;
  logic               arith_ovf;
  logic [XLEN-1:0]    logic_res;
  logic [XLEN-1:0]    cmp_res;
  logic [XLEN-1:0]    shift_res;
  logic [XLEN-1:0]    lui_res;
  logic [SHAMT_W-1:0] sh_amt;
  logic [XLEN-1:0]    unit_res;
  logic               trap_hit;

  alu_decode u_dec (
    .op_i   (op_i),
    .ctrl_o (ctrl)
  );

  assign imm_zx = {{PAD_W{1'b0}}, imm_i[IMM_W-1:0]};
  assign opnd_b = !ctrl.use_imm ? b_i : (ctrl.imm_zext ? imm_zx : imm_i);

  alu_addsub #(.XLEN(XLEN)) u_arith (
    .a_i   (a_i),
    .b_i   (opnd_b),
    .sub_i (ctrl.sub),
    .sum_o (arith_res),
    .ovf_o (arith_ovf)
  );

  alu_logic #(.XLEN(XLEN)) u_logic (
    .a_i   (a_i),
    .b_i   (opnd_b),
    .fn_i  (ctrl.log_fn),
    .res_o (logic_res)
  );

  alu_cmp #(.XLEN(XLEN)) u_cmp (
    .a_i   (a_i),
    .b_i   (opnd_b),
    .uns_i (ctrl.cmp_uns),
    .res_o (cmp_res)
  );

  assign sh_amt = ctrl.sh_var ? a_i[SHAMT_W-1:0] : shamt_i;

  alu_shift #(.XLEN(XLEN), .SHAMT_W(SHAMT_W)) u_shift (
    .val_i (b_i),
    .amt_i (sh_amt),
    .fn_i  (ctrl.sh_fn),
    .res_o (shift_res)
  );

  assign lui_res = {imm_i[IMM_W-1:0], {PAD_W{1'b0}}};

  always_comb begin
    unique case (ctrl.unit)
      UNIT_ARITH: unit_res = arith_res;
      UNIT_LOGIC: unit_res = logic_res;
      UNIT_LUI:   unit_res = lui_res;
      UNIT_CMP:   unit_res = cmp_res;
      UNIT_SHIFT: unit_res = shift_res;
      default:    unit_res = '0;
    endcase
  end

  assign trap_hit  = ctrl.legal && (ctrl.unit == UNIT_ARITH) && ctrl.trap && arith_ovf;
  assign ovf_o     = trap_hit;
  assign illegal_o = !ctrl.legal;
  assign valid_o   = ctrl.legal && !trap_hit;
  assign result_o  = valid_o ? unit_res : '0;

endmodule

// File: rtl/alu_exec_chk.sv
module alu_exec_chk
  import alu_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int IMM_W = 16
) (
  input logic [OP_W-1:0] op_i,
  input logic [XLEN-1:0] a_i,
  input logic [XLEN-1:0] b_i,
  input logic [XLEN-1:0] imm_i,
  input logic [XLEN-1:0] result_o,
  input logic            valid_o,
  input logic            ovf_o,
  input logic            illegal_o
);

  localparam int M = XLEN - 1;

  logic [XLEN-1:0] s_ab, s_ai, d_ab;

  assign s_ab = a_i + b_i;
  assign s_ai = a_i + imm_i;
  assign d_ab = a_i - b_i;

  always_comb begin
    if (op_i == OP_ADD)
      p_add_ovf_r1: assert (ovf_o == ((a_i[M] == b_i[M]) && (s_ab[M] != a_i[M])))
        else $error("R1 add overflow flag");
    if (op_i == OP_ADDI)
      p_addi_ovf_r1: assert (ovf_o == ((a_i[M] == imm_i[M]) && (s_ai[M] != a_i[M])))
        else $error("R1 addi overflow flag");
    if (ovf_o)
      p_ovf_no_write_r1: assert (!valid_o && (result_o == '0))
        else $error("R1 write on overflow");
    if (op_i == OP_SUB)
      p_sub_ovf_r2: assert (ovf_o == ((a_i[M] != b_i[M]) && (d_ab[M] != a_i[M])))
        else $error("R2 sub overflow flag");
    if (op_i == OP_ADDU || op_i == OP_SUBU || op_i == OP_ADDIU)
      p_no_overflow_r3: assert (!ovf_o && valid_o)
        else $error("R3 wrapping op trapped");
    if (op_i == OP_LUI)
      p_lui_r6: assert (result_o == {imm_i[IMM_W-1:0], {(XLEN-IMM_W){1'b0}}})
        else $error("R6 lui");
    if (op_i == OP_SLT || op_i == OP_SLTU || op_i == OP_SLTI || op_i == OP_SLTIU)
      p_slt_bool_r7: assert (valid_o && (result_o[XLEN-1:1] == '0))
        else $error("R7 compare not boolean");
    if (illegal_o)
      p_illegal_r11: assert (!valid_o && !ovf_o && (result_o == '0))
        else $error("R11 illegal select outputs");
    if (!illegal_o && !ovf_o)
      p_legal_valid_r12: assert (valid_o)
        else $error("R12 legal op not valid");
  end

endmodule

bind alu_exec alu_exec_chk #(.XLEN(XLEN), .IMM_W(IMM_W)) u_chk (
  .op_i      (op_i),
  .a_i       (a_i),
  .b_i       (b_i),
  .imm_i     (imm_i),
  .result_o  (result_o),
  .valid_o   (valid_o),
  .ovf_o     (ovf_o),
  .illegal_o (illegal_o)
);

// File: tb/alu_exec_tb_top.sv
`timescale 1ns/1ps
module alu_exec_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  op;
  logic [31:0] a, b, imm;
  logic [4:0]  sh;
  logic [31:0] result;
  logic        valid, ovf, illegal;
  int          n_checks = 0;
  int          n_err = 0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  alu_exec dut_i (
    .op_i      (op),
    .a_i       (a),
    .b_i       (b),
    .imm_i     (imm),
    .shamt_i   (sh),
    .result_o  (result),
    .valid_o   (valid),
    .ovf_o     (ovf),
    .illegal_o (illegal)
  );

  function automatic string tag_of(input logic [4:0] o);
    case (o)
      5'd0, 5'd16:          return "R1";
      5'd2:                 return "R2";
      5'd1, 5'd3, 5'd17:    return "R3";
      5'd4, 5'd5, 5'd6, 5'd7: return "R4";
      5'd8, 5'd9, 5'd10:    return "R5";
      5'd11:                return "R6";
      5'd12, 5'd13, 5'd14:  return "R7";
      5'd15:                return "R8";
      5'd18, 5'd19, 5'd20:  return "R9";
      5'd21, 5'd22, 5'd23:  return "R10";
      default:              return "R11";
    endcase
  endfunction

  task automatic expect_of(input logic [4:0] o, input logic [31:0] x, y, im,
                           input logic [4:0] s, output logic [31:0] r,
                           output logic v, output logic f, output logic il);
    logic signed [32:0] w;
    logic [31:0] zi;
    zi = {16'h0, im[15:0]};
    r = 32'h0; f = 1'b0; il = 1'b0; v = 1'b1;
    case (o)
      5'd0:  begin w = {x[31], x} + {y[31], y};   r = w[31:0]; f = w[32] ^ w[31]; end
      5'd16: begin w = {x[31], x} + {im[31], im}; r = w[31:0]; f = w[32] ^ w[31]; end
      5'd2:  begin w = {x[31], x} - {y[31], y};   r = w[31:0]; f = w[32] ^ w[31]; end
      5'd1:  r = x + y;
      5'd3:  r = x - y;
      5'd17: r = x + im;
      5'd4:  r = x & y;
      5'd5:  r = x | y;
      5'd6:  r = x ^ y;
      5'd7:  r = ~(x | y);
      5'd8:  r = x & zi;
      5'd9:  r = x | zi;
      5'd10: r = x ^ zi;
      5'd11: r = im << 16;
      5'd12: r = ($signed(x) < $signed(y)) ? 32'd1 : 32'd0;
      5'd13: r = (x < y) ? 32'd1 : 32'd0;
      5'd14: r = ($signed(x) < $signed(im)) ? 32'd1 : 32'd0;
      5'd15: r = (x < im) ? 32'd1 : 32'd0;
      5'd18: r = y << s;
      5'd19: r = y >> s;
      5'd20: r = $signed(y) >>> s;
      5'd21: r = y << x[4:0];
      5'd22: r = y >> x[4:0];
      5'd23: r = $signed(y) >>> x[4:0];
      default: begin v = 1'b0; il = 1'b1; end
    endcase
    if (f) begin v = 1'b0; r = 32'h0; end
  endtask

  task automatic cmp(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s op=%0d a=%h b=%h imm=%h sh=%0d: actual=%h expected=%h",
               tag, what, op, a, b, imm, sh, act, exp);
    end
  endtask

  task automatic run_vec(input logic [4:0] o, input logic [31:0] x, y, im,
                         input logic [4:0] s);
    logic [31:0] er;
    logic ev, ef, ei;
    string t, tf;
    @(posedge clk);
    op = o; a = x; b = y; imm = im; sh = s;
    @(negedge clk);
    expect_of(o, x, y, im, s, er, ev, ef, ei);
    t  = tag_of(o);
    tf = (o > 5'd23) ? "R11" : "R12";
    cmp(t, "result", result, er);
    cmp(t, "ovf", {31'h0, ovf}, {31'h0, ef});
    cmp(tf, "valid", {31'h0, valid}, {31'h0, ev});
    cmp(tf, "illegal", {31'h0, illegal}, {31'h0, ei});
  endtask

  function automatic logic [31:0] sx16(input logic [15:0] v);
    return {{16{v[15]}}, v};
  endfunction

  logic [31:0] edges [8];
  logic [15:0] imms  [8];

  initial begin
    logic [31:0] rng;
    edges = '{32'h0, 32'h1, 32'h7fff_ffff, 32'h8000_0000,
              32'hffff_ffff, 32'h0000_ffff, 32'h1234_5678, 32'hfffe_0001};
    imms  = '{16'h0, 16'h1, 16'h7fff, 16'h8000,
              16'hffff, 16'h1234, 16'h00ff, 16'hff00};
    op = 5'd0; a = '0; b = '0; imm = '0; sh = '0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    // idle inputs: ADD of zeros gives valid zero result (R12)
    @(negedge clk);
    cmp("R12", "reset result", result, 32'h0);
    cmp("R12", "reset valid", {31'h0, valid}, 32'h1);
    cmp("R12", "reset flags", {30'h0, ovf, illegal}, 32'h0);

    // every select against the signed/unsigned boundary values
    for (int o = 0; o < 32; o++)
      for (int i = 0; i < 8; i++)
        for (int j = 0; j < 8; j++)
          run_vec(5'(o), edges[i], edges[j], sx16(imms[(i + j) % 8]),
                  5'((i * 5 + j * 3) % 32));

    // every shift amount, with upper bits of the amount register set (R10)
    for (int o = 18; o < 24; o++)
      for (int s = 0; s < 32; s++) begin
        run_vec(5'(o), 32'ha5a5_a5a0 | 32'(s), 32'h8123_4567, 32'h0, 5'(s));
        run_vec(5'(o), 32'h5a5a_5a40 | 32'(s), 32'h7654_3210, 32'h0, 5'(31 - s));
      end

    // pseudo-random operands and selects
    rng = 32'h1bad_5eed;
    for (int n = 0; n < 2000; n++) begin
      logic [31:0] x, y, z;
      rng = rng ^ (rng << 13); rng = rng ^ (rng >> 17); rng = rng ^ (rng << 5);
      x = rng;
      rng = rng ^ (rng << 13); rng = rng ^ (rng >> 17); rng = rng ^ (rng << 5);
      y = rng;
      rng = rng ^ (rng << 13); rng = rng ^ (rng >> 17); rng = rng ^ (rng << 5);
      z = rng;
      run_vec(z[4:0], x, y, sx16(z[31:16]), z[9:5]);
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_err++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_checks);
      $finish;
    end
  end

endmodule